// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire control port. A host uses it to reach a small bank of 8-bit configuration registers. The three wires are an active-low select, a serial clock and one shared data wire. Every transaction is 16 serial clocks long and holds three fields: a direction bit, a 7-bit register address and an 8-bit data byte. The address and the data are each sent most significant bit first.

A write collects its byte and changes the register only when the select wire is released. A read turns the shared data wire around halfway through the frame, and the block then shifts the register contents back to the host. The data wire is split into an input, an output and an output enable, so that the pad cell at the chip edge builds the actual bidirectional pin.

The serial pins are oversampled in the system clock domain through synchronizers. The host must therefore hold each level of the serial clock and of the select for at least four system clocks. At the 250 MHz system clock this sets a serial clock limit well above 5 MHz. Each committed write appears as a one-cycle strobe together with its address and data. The strobe cannot be stalled: a write is final once the select rises, so there is no back-pressure path. The whole register bank is also brought out as a parallel bus.

Top module: `tw_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, register i (0 to 17) holds the value ((i*29) mod 256) XOR 0xA5.
- R2: A frame is sampled on rising serial clock edges in this order: a direction bit (1 = write, 0 = read), address bits A6 to A0, then data bits D7 to D0. A complete write to an address from 0x00 to 0x11 raises `wr_stb` for exactly one cycle, with `wr_addr` and `wr_data` equal to the sent values. The register takes the byte in the cycle after that strobe.
- R3: No register changes while the select is low, including after all 16 bits have arrived. The change happens only after the select rises.
- R4: If the select rises after fewer than 16 serial clock rising edges, no strobe is issued and no register changes.
- R5: In a read frame, `sdio_oe` goes high at the falling edge that follows the 8th rising edge. Before each of rising edges 9 to 16, `sdio_o` carries D7 down to D0 of the addressed register.
- R6: `sdio_oe` is low whenever the select is high, and it drops once the select rises. It is also low during the first 8 serial clocks of every frame.
- R7: A read of an address from 0x12 to 0x7F shifts out 0x00.
- R8: A write to an address from 0x12 to 0x7F produces no strobe and leaves every register unchanged.
- R9: Serial clock edges after the 16th are ignored. The frame still commits the data byte carried by bits 9 to 16.
- R10: Every falling edge of the select starts a new frame at bit 0, whatever happened in the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset; returns registers to their defaults |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Level seen on the shared data pin |
| sdio_o | output | 1 | Data the block drives during a read |
| sdio_oe | output | 1 | High while the block drives the shared data pin |
| regs_o | output | 144 | Parallel register bank; register i sits at bits [8i+7:8i] |
| wr_stb | output | 1 | One-cycle pulse for each committed write |
| wr_addr | output | 7 | Address of the committed write |
| wr_data | output | 8 | Byte of the committed write |

## Verification
The hardest cases to reach are frames that end at the wrong moment: the select rising one clock short of a full frame, or a frame given extra clocks. These must be told apart from exact 16-clock frames, both for commits and for turnaround. The random stimulus therefore draws the serial clock count per frame from a spread around 16 and mixes out-of-range addresses into reads and writes. Directed frames pin down counts of 15, 16 and 17. A reset in the middle of a run checks that the defaults come back after registers have been rewritten.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int REG_W = 8;

  // Reset value of register idx.
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    logic [31:0] prod;
    prod = 32'(idx) * 32'd29;
    return prod[REG_W-1:0] ^ 8'hA5;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= RST_VAL;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NREGS = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int HDR   = 1 + AW;
  localparam int FRAME = HDR + DW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] C_HDR   = CW'(HDR);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME);

  logic          cs_q, sclk_q;
  logic [CW-1:0] cnt;
  logic [HDR-1:0] hdr;
  logic [DW-1:0]  dat;
  logic [DW-1:0]  obuf;

  wire cs_rise   = cs_s & ~cs_q;
  wire cs_fall   = ~cs_s & cs_q;
  wire sclk_rise = sclk_s & ~sclk_q;
  wire sclk_fall = ~sclk_s & sclk_q;
  wire is_write  = hdr[HDR-1];
  wire in_range  = 32'(hdr[AW-1:0]) < NREGS;

  assign rd_addr = hdr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      cnt     <= '0;
      hdr     <= '0;
      dat     <= '0;
      obuf    <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      wr_stb <= 1'b0;
      if (cs_s) begin
        sdo_oe <= 1'b0;
        if (cs_rise && cnt == C_FRAME && is_write && in_range) begin
          wr_stb  <= 1'b1;
          wr_addr <= hdr[AW-1:0];
          wr_data <= dat;
        end
      end else if (cs_fall) begin
        cnt    <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (sclk_rise && cnt < C_FRAME) begin
          cnt <= cnt + 1'b1;
          if (cnt < C_HDR) hdr <= {hdr[HDR-2:0], sdi_s};
          else             dat <= {dat[DW-2:0], sdi_s};
        end
        if (sclk_fall && !is_write) begin
          if (cnt == C_HDR) begin
            sdo_oe <= 1'b1;
            sdo    <= rd_data[DW-1];
            obuf   <= {rd_data[DW-2:0], 1'b0};
          end else if (cnt > C_HDR && cnt < C_FRAME && sdo_oe) begin
            sdo  <= obuf[DW-1];
            obuf <= {obuf[DW-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NREGS = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [AW-1:0]       raddr,
  output logic [DW-1:0]       rdata,
  output logic [NREGS*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= DW'(tw_pkg::reg_default(g));
      else if (we && waddr == AW'(g))      mem[g] <= wdata;
    end
    assign regs_o[g*DW +: DW] = mem[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (raddr == AW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NREGS = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdio_i,
  output logic                sdio_o,
  output logic                sdio_oe,
  output logic [NREGS*DW-1:0] regs_o,
  output logic                wr_stb,
  output logic [AW-1:0]       wr_addr,
  output logic [DW-1:0]       wr_data
);
  logic [2:0]    pins_s;
  logic          cs_s, sclk_s, sdi_s;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdio_i}), .q(pins_s)
  );
  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  tw_frame #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_addr(rd_addr), .rd_data(rd_data), .sdo(sdio_o), .sdo_oe(sdio_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tw_regfile #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_stb), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/tw_regbank_chk.sv
module tw_regbank_chk #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NREGS = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_s,
  input logic                sdio_oe,
  input logic [NREGS*DW-1:0] regs_o,
  input logic                wr_stb,
  input logic [AW-1:0]       wr_addr,
  input logic [DW-1:0]       wr_data
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= wr_addr;
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREGS; i++)
      if (addr_q == AW'(i)) sel = regs_o[i*DW +: DW];
  end

  // R2: strobe lasts one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R2: the committed byte lands in the addressed register
  p_commit_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sel == $past(wr_data));

  // R3: registers move only after a strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o));

  // R3: no strobe while the select is low
  p_commit_on_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> cs_s);

  // R8: strobes only for implemented addresses
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (32'(wr_addr) < NREGS));

  // R6: driver released while the select is high
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdio_oe);
endmodule

bind tw_regbank tw_regbank_chk #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdio_oe(sdio_oe), .regs_o(regs_o),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tw_regbank_tb.sv
`timescale 1ns/1ps
module tw_regbank_tb;
  localparam int AW = 7, DW = 8, NREGS = 18, HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, wr_stb;
  logic [NREGS*DW-1:0] regs_o;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #2 clk = ~clk;

  tw_regbank u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .regs_o(regs_o), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data));

  int tests = 0, fails = 0, stb_cnt = 0;
  logic [AW-1:0] stb_addr;
  logic [DW-1:0] stb_data;
  logic [DW-1:0] model [NREGS];
  logic [DW-1:0] last_rd;

  always @(negedge clk) if (rst_n && wr_stb) begin
    stb_cnt++; stb_addr = wr_addr; stb_data = wr_data;
  end

  function automatic logic [DW-1:0] dflt(input int i);
    return DW'(((i * 29) % 256) ^ 165);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREGS; i++) check(req, 32'(regs_o[i*DW +: DW]), 32'(model[i]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0;
    tick(4);
    for (int i = 0; i < NREGS; i++) model[i] = dflt(i);
    check_bank("R1");
    rst_n = 1'b1;
    tick(4);
    check_bank("R1");
  endtask

  // One frame with nclk serial clocks.
  task automatic frame(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int nclk);
    logic [15:0] bits;
    int s0;
    bits = {wr, a, d};
    s0 = stb_cnt;
    last_rd = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nclk; i++) begin
      if (i < 16 && (wr || i < 8)) sdio_i = bits[15-i];
      else sdio_i = 1'b0;
      tick(HALF);
      if (i == 7 || i == 0) check("R6", 32'(sdio_oe), 0);
      if (!wr && i >= 8 && i < 16) begin
        check("R5", 32'(sdio_oe), 1);
        last_rd[15-i] = sdio_o;
      end
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    check("R3", 32'(stb_cnt - s0), 0);
    check_bank("R3");
    cs_n = 1'b1;
    tick(10);
    check("R6", 32'(sdio_oe), 0);
    if (wr && nclk >= 16 && 32'(a) < NREGS) begin
      check("R2", 32'(stb_cnt - s0), 1);
      check("R2", 32'({stb_addr, stb_data}), 32'({a, d}));
      model[a] = d;
    end else if (wr && nclk >= 16) begin
      check("R8", 32'(stb_cnt - s0), 0);
    end else begin
      check(nclk < 16 ? "R4" : "R2", 32'(stb_cnt - s0), 0);
    end
    if (!wr && nclk >= 16)
      check(32'(a) < NREGS ? "R5" : "R7", 32'(last_rd), 32'(32'(a) < NREGS ? model[a] : 8'h00));
    check_bank(nclk >= 16 ? "R9" : "R4");
    tick(4);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd4646;
    void'($urandom(seed));
    do_reset();
    // directed corner cases
    frame(1'b1, 7'h00, 8'h3C, 16);           // R2 lowest address
    frame(1'b0, 7'h00, 8'h00, 16);           // R5 readback
    frame(1'b1, 7'h11, 8'hC3, 16);           // R2 top implemented address
    frame(1'b0, 7'h11, 8'h00, 16);
    frame(1'b1, 7'h05, 8'h77, 15);           // R4 one short
    frame(1'b1, 7'h05, 8'h81, 17);           // R9 one extra
    frame(1'b0, 7'h05, 8'h00, 18);           // R9 read with extra
    frame(1'b1, 7'h12, 8'hFF, 16);           // R8 just beyond
    frame(1'b1, 7'h7F, 8'h55, 16);           // R8 last address
    frame(1'b0, 7'h12, 8'h00, 16);           // R7
    frame(1'b0, 7'h4F, 8'h00, 16);           // R7
    frame(1'b1, 7'h09, 8'h11, 3);            // R10 abort then fresh frame
    frame(1'b1, 7'h09, 8'h99, 16);           // R10
    frame(1'b0, 7'h09, 8'h00, 16);
    // random mix
    for (int n = 0; n < 70; n++) begin
      logic wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int k, nclk;
      wr = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(18, 127)) : AW'($urandom_range(0, NREGS - 1));
      d = DW'($urandom);
      k = $urandom_range(0, 9);
      nclk = (k < 6) ? 16 : (k < 8) ? $urandom_range(1, 15) : $urandom_range(17, 20);
      frame(wr, a, d, nclk);
    end
    // reset after registers were rewritten
    do_reset();
    frame(1'b0, 7'h0A, 8'h00, 16);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule